// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter

This block lets software drive an external serial EEPROM one bit at a time over pins it shares with a memory port. Software writes a control byte with the request bit set. The block waits until the memory port reports that it is idle. It then takes the pins, steers them to the EEPROM and raises a ready flag. From then on, three control bits drive the EEPROM chip select, clock and data input. A fourth bit reads back the EEPROM data output, sampled through one flop.

Once access is held, every further write to the control byte drops the ready flag. The flag comes back after a fixed 800 ns delay. Software polls it as a pacing timer between clock edges of the serial protocol. A write that lands while the delay is running starts the delay again. Writing the request bit as zero gives the pins back to the memory port and clears ready.

The delay is a cycle count derived from two parameters: the clock period in picoseconds and the delay in picoseconds. The default is 200 cycles at 250 MHz.

Top module: `ee_port_arb`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x00 and `pin_sel`, `ee_cs`, `ee_sk`, `ee_dout` are all 0.
- R2: Access is granted at the first clock edge after the request bit (bit 5 of the control byte) is stored at which `mem_busy` is low. While `mem_busy` stays high, no grant happens. `pin_sel` follows the grant one cycle later.
- R3: The first grant carries no delay. The ready bit (bit 4 of `ctl_rdata`) reads 1 right after the grant edge.
- R4: A write with bit 5 = 1 while access is held clears ready at the write edge. Ready returns to 1 exactly DELAY_CYC edges later (200 by default).
- R5: A write that arrives while the delay is running restarts the full DELAY_CYC count from the new write edge.
- R6: While access is held, control bits 3 (chip select), 2 (clock) and 1 (data to EEPROM) reach `ee_cs`, `ee_sk` and `ee_dout` one cycle after the write edge.
- R7: While access is not held, `ee_cs`, `ee_sk`, `ee_dout` and `pin_sel` stay 0, whatever the stored control bits are.
- R8: While access is held, bit 0 of `ctl_rdata` shows `ee_din` as sampled at the previous clock edge. Otherwise bit 0 reads 0.
- R9: A write with bit 5 = 0 clears the request, the grant and ready at the write edge. The pins return to the memory port one cycle later, and no new grant follows.
- R10: Bits 7 and 6 of `ctl_rdata` always read 0. Values written to bits 7, 6, 4 and 0 have no effect on the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| mem_busy | input | 1 | Memory port is servicing another request |
| ee_din | input | 1 | Serial data from the EEPROM |
| pin_sel | output | 1 | Shared pins steered to the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_dout | output | 1 | Serial data to the EEPROM |

## Verification
The results fall due at fixed edges:
- Register-visible state (request, grant and clearing of ready) changes at the write edge itself.
- The first ready and the grant appear at the first edge after the request with the memory port idle.
- The pins and `pin_sel` lag the register state by one edge.
- Ready returns after exactly DELAY_CYC edges.

Inputs change on falling edges and outputs are sampled on falling edges, so the bench counts the edges passed since each write. Ready is checked one edge before and at its due edge, which pins the delay to the exact cycle. The restart check samples past the point where the original delay would have ended.

// File: rtl/ee_arb_pkg.sv
package ee_arb_pkg;
  // control byte field positions
  localparam int BIT_XACK = 7;
  localparam int BIT_XREQ = 6;
  localparam int BIT_REQ  = 5;
  localparam int BIT_RDY  = 4;
  localparam int BIT_CS   = 3;
  localparam int BIT_SK   = 2;
  localparam int BIT_DOUT = 1;
  localparam int BIT_DIN  = 0;

  typedef struct packed {
    logic cs;
    logic sk;
    logic dout;
  } ee_drv_t;
endpackage

// File: rtl/ee_grant_ctl.sv
module ee_grant_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_req,
  input  logic mem_busy,
  output logic req_q,
  output logic grant_q,
  output logic grant_set,
  output logic release_o
);
  assign release_o = wr_en & ~wr_req;
  assign grant_set = req_q & ~grant_q & ~mem_busy & ~release_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      if (wr_en) req_q <= wr_req;
      if (release_o)      grant_q <= 1'b0;
      else if (grant_set) grant_q <= 1'b1;
    end
  end

  // R2
  grant_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_q) |-> ($past(!mem_busy) && $past(req_q)));

  // R9
  release_drops_chk: assert property (@(posedge clk) disable iff (rst)
    release_o |=> (!grant_q && !req_q));
endmodule

// File: rtl/ee_pace_timer.sv
module ee_pace_timer #(
  parameter int DELAY_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic grant_set,
  input  logic restart,
  output logic rdy_q
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      rdy_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
      rdy_q <= 1'b0;
    end else if (grant_set) begin
      rdy_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_q <= 1'b0;
        rdy_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R4
  rdy_low_run_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> !rdy_q);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q < CW'(DELAY_CYC)));

  // R5
  restart_load_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && !clear) |=> (!rdy_q && run_q && cnt_q == LOAD));

  // R3
  grant_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_set && !clear && !restart) |=> rdy_q);
endmodule

// File: rtl/ee_pin_stage.sv
module ee_pin_stage
  import ee_arb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    grant,
  input  ee_drv_t drv,
  input  logic    ee_din,
  output logic    pin_sel,
  output logic    ee_cs,
  output logic    ee_sk,
  output logic    ee_dout,
  output logic    din_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_sel <= 1'b0;
      ee_cs   <= 1'b0;
      ee_sk   <= 1'b0;
      ee_dout <= 1'b0;
      din_q   <= 1'b0;
    end else begin
      pin_sel <= grant;
      ee_cs   <= grant & drv.cs;
      ee_sk   <= grant & drv.sk;
      ee_dout <= grant & drv.dout;
      din_q   <= grant & ee_din;
    end
  end

  // R7
  cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(grant) |-> (!ee_cs && !ee_sk && !ee_dout && !pin_sel));

  // R8
  din_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(grant) |-> !din_q);
endmodule

// File: rtl/ee_port_arb.sv
module ee_port_arb
  import ee_arb_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int DELAY_PS      = 800000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       mem_busy,
  input  logic       ee_din,
  output logic       pin_sel,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_dout
);
  localparam int DELAY_CYC = (DELAY_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

  logic    req_q, grant_q, grant_set, release_w, rdy_q, din_q;
  ee_drv_t drv_q;
  logic    unused_wbits;

  assign unused_wbits = ^{ctl_wdata[BIT_XACK], ctl_wdata[BIT_XREQ],
                          ctl_wdata[BIT_RDY], ctl_wdata[BIT_DIN]};

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= '0;
    end else if (ctl_wr) begin
      drv_q.cs   <= ctl_wdata[BIT_CS];
      drv_q.sk   <= ctl_wdata[BIT_SK];
      drv_q.dout <= ctl_wdata[BIT_DOUT];
    end
  end

  ee_grant_ctl u_grant (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ctl_wr),
    .wr_req    (ctl_wdata[BIT_REQ]),
    .mem_busy  (mem_busy),
    .req_q     (req_q),
    .grant_q   (grant_q),
    .grant_set (grant_set),
    .release_o (release_w)
  );

  ee_pace_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clear     (release_w),
    .grant_set (grant_set),
    .restart   (ctl_wr & ctl_wdata[BIT_REQ] & grant_q),
    .rdy_q     (rdy_q)
  );

  ee_pin_stage u_pins (
    .clk     (clk),
    .rst     (rst),
    .grant   (grant_q),
    .drv     (drv_q),
    .ee_din  (ee_din),
    .pin_sel (pin_sel),
    .ee_cs   (ee_cs),
    .ee_sk   (ee_sk),
    .ee_dout (ee_dout),
    .din_q   (din_q)
  );

  assign ctl_rdata = {2'b00, req_q, rdy_q, drv_q.cs, drv_q.sk, drv_q.dout, din_q};

  // R10
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[7:6] == 2'b00);
endmodule

// File: tb/ee_port_arb_tb.sv
module ee_port_arb_tb_top;
  localparam int DLY = 200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       mem_busy = 1'b0;
  logic       ee_din = 1'b0;
  logic       pin_sel, ee_cs, ee_sk, ee_dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ee_port_arb dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .mem_busy(mem_busy), .ee_din(ee_din),
    .pin_sel(pin_sel), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_dout(ee_dout)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // write edge is the next rising edge; returns at the falling edge after it
  task automatic wr(input logic [7:0] d);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
    ctl_wdata = '0;
  endtask

  task automatic pins(output logic [7:0] p);
    p = {4'h0, pin_sel, ee_cs, ee_sk, ee_dout};
  endtask

  task automatic t_reset;
    logic [7:0] p;
    pins(p);
    chk("R1 rdata after reset", ctl_rdata, 8'h00);
    chk("R1 pins after reset", p, 8'h00);
  endtask

  task automatic t_grant;
    logic [7:0] p;
    mem_busy = 1'b1;
    wr(8'h2E);
    chk("R2 request stored", ctl_rdata, 8'h2E);
    repeat (3) @(negedge clk);
    pins(p);
    chk("R2 no grant while busy", ctl_rdata[4], 1'b0);
    chk("R7 pins idle before grant", p, 8'h00);
    mem_busy = 1'b0;
    @(negedge clk);
    chk("R3 ready at grant edge", ctl_rdata[4], 1'b1);
    chk("R2 pin_sel not yet", pin_sel, 1'b0);
    @(negedge clk);
    pins(p);
    chk("R6 pins after grant", p, 8'h0F);
  endtask

  task automatic t_pace;
    logic [7:0] p;
    wr(8'h28);
    chk("R4 ready drops at write", ctl_rdata[4], 1'b0);
    @(negedge clk);
    pins(p);
    chk("R6 new pin values", p, 8'h0C);
    repeat (DLY - 2) @(negedge clk);
    chk("R4 ready low one edge early", ctl_rdata[4], 1'b0);
    @(negedge clk);
    chk("R4 ready back on time", ctl_rdata[4], 1'b1);
  endtask

  task automatic t_restart;
    wr(8'h20);
    repeat (99) @(negedge clk);
    chk("R5 running before restart", ctl_rdata[4], 1'b0);
    wr(8'h22);
    repeat (DLY - 1) @(negedge clk);
    chk("R5 ready still low after old deadline", ctl_rdata[4], 1'b0);
    @(negedge clk);
    chk("R5 ready after restarted delay", ctl_rdata[4], 1'b1);
    chk("R6 dout bit", ee_dout, 1'b1);
  endtask

  task automatic t_din;
    ee_din = 1'b1;
    @(negedge clk);
    chk("R8 din high seen", ctl_rdata[0], 1'b1);
    ee_din = 1'b0;
    @(negedge clk);
    chk("R8 din low seen", ctl_rdata[0], 1'b0);
  endtask

  task automatic t_ignore;
    wr(8'hF1);
    chk("R10 ignored bits", ctl_rdata, 8'h20);
    repeat (DLY) @(negedge clk);
    chk("R10 ready after delay", ctl_rdata, 8'h30);
  endtask

  task automatic t_release;
    logic [7:0] p;
    wr(8'h0E);
    chk("R9 request and ready cleared", ctl_rdata, 8'h0E);
    @(negedge clk);
    pins(p);
    chk("R9 pins released", p, 8'h00);
    ee_din = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 no regrant", ctl_rdata[5:4], 2'b00);
    chk("R8 din masked when idle", ctl_rdata[0], 1'b0);
    pins(p);
    chk("R7 pins idle after release", p, 8'h00);
    ee_din = 1'b0;
  endtask

  task automatic t_regrant;
    wr(8'h20);
    chk("R3 ready not before grant", ctl_rdata[4], 1'b0);
    @(negedge clk);
    chk("R3 immediate ready on regrant", ctl_rdata[4], 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_grant();
    t_pace();
    t_restart();
    t_din();
    t_ignore();
    t_release();
    t_regrant();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule